// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects 32 interrupt request lines and decides, each cycle, whether the core should start a new handler. Each line has an enable bit, a pending bit, an active bit and a 4-bit implemented priority. All of this state is reached through a word-wide register port with combinational reads and single-cycle writes. A high sample on a request line sets its pending bit. Among pending and enabled lines the controller picks the most urgent one. It raises `take_o` only when that line's pre-emption level is strictly more urgent than the level now running.

A 3-bit grouping field divides the four priority bits into a pre-emption part and a sub-priority part. The sub-priority only orders waiting requests, and only the pre-emption part can interrupt a running handler. Running levels are kept on a stack. When `done_i` ends the current handler, the controller either drops back to the level underneath or, in the same cycle, chains straight into a waiting request that beats that level.

The core must treat a cycle with `take_o` high as an accepted entry into handler `take_id_o`. It pulses `done_i` for one cycle when a handler returns.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `rst_ni` is low, all enable, pending, active, priority and grouping state is zero, `take_o` is 0 and `run_level_o` reads 16 (idle).
- R2: Word 0 sets enable bits and word 1 clears them, one bit per line; both read back the enable bits. Word 2 sets pending bits and word 3 clears them; both read back the pending bits. In all four, a written 0 leaves the bit unchanged.
- R3: Words 8 to 15 hold the priorities, four per word. Line n sits in word 8+n/4, bits [(n mod 4)*8+7 : (n mod 4)*8+4]. The low nibble of every byte reads 0 and ignores writes.
- R4: Word 5 bits [10:8] hold the grouping value g, read back in place. For g = 3,4,5,6,7, the pre-emption level is the priority shifted right by g-3. Values 0 to 2 act as 3.
- R5: A request is taken only if its pre-emption level is numerically strictly lower than the running level. An equal level never pre-empts, whatever its sub-priority.
- R6: Among pending and enabled lines, the lowest full 4-bit priority wins. This means lowest pre-emption level first, then lowest sub-priority. Remaining ties go to the lowest line number.
- R7: In a `done_i` cycle, the best waiting request is taken at once (tail-chaining) if its level beats the level below the finishing handler. Otherwise that lower level resumes.
- R8: When `take_o` is high, at the next edge the pending bit of `take_id_o` clears and its active bit sets. `done_i` clears the active bit of the finishing handler. Word 4 reads the active bits.
- R9: A line sampled high on an edge sets its pending bit. Request lines are ignored while reset is asserted.
- R10: Up to 16 nested levels are held. `run_level_o` shows the level of the innermost handler, and each `done_i` without a take restores the level beneath it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Request lines, sampled each edge |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational |
| take_o | output | 1 | Request accepted this cycle |
| take_id_o | output | 5 | Line number being accepted |
| done_i | input | 1 | Current handler finishes this cycle |
| run_level_o | output | 5 | Running pre-emption level, 16 when idle |

## Verification
The assertions check, on every cycle, the following properties:
- Any take outside a `done_i` cycle is strictly more urgent than the running level, and becomes the new running level one cycle later.
- The taken line was pending and enabled.
- The stack never holds more than 16 entries.
- Finishing the last handler without a take returns to idle.

Only the bench scenarios can show the remaining behaviour: the ordering by sub-priority and line number, the effect of each grouping value, the choice between resuming and tail-chaining, the register packing, and the write-one semantics. Each of these needs a chosen sequence of priorities and requests with known answers.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NUM_IRQ   = 32;
  localparam int PRIO_W    = 4;
  localparam int ID_W      = $clog2(NUM_IRQ);
  localparam int NUM_LVL   = 1 << PRIO_W;
  localparam int LVL_W     = $clog2(NUM_LVL + 1);
  localparam int ADDR_W    = 4;
  localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(NUM_LVL);

  localparam logic [ADDR_W-1:0] A_SET_EN   = 4'd0;
  localparam logic [ADDR_W-1:0] A_CLR_EN   = 4'd1;
  localparam logic [ADDR_W-1:0] A_SET_PEND = 4'd2;
  localparam logic [ADDR_W-1:0] A_CLR_PEND = 4'd3;
  localparam logic [ADDR_W-1:0] A_ACTIVE   = 4'd4;
  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd5;
  localparam logic [ADDR_W-1:0] A_PRIO     = 4'd8;

  typedef logic [PRIO_W-1:0] prio_t;

  // grouping value -> right shift applied to the priority to get the pre-emption level
  function automatic logic [2:0] grp_shift(input logic [2:0] g);
    return (g < 3'd3) ? 3'd0 : g - 3'd3;
  endfunction
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              accept_i,
  input  logic [ID_W-1:0]   accept_id_i,
  input  logic              retire_i,
  input  logic [ID_W-1:0]   retire_id_i,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] en_o,
  output prio_t             prio_o [NUM_IRQ],
  output logic [2:0]        group_o
);
  localparam int PER_WORD = 32 / 8;

  logic [NUM_IRQ-1:0] pend_d, act_q, act_d;

  always_comb begin
    pend_d = pend_o | irq_i;
    if (we_i && addr_i == A_SET_PEND) pend_d = pend_d | wdata_i;
    if (we_i && addr_i == A_CLR_PEND) pend_d = pend_d & ~wdata_i;
    if (accept_i) pend_d[accept_id_i] = 1'b0;
    act_d = act_q;
    if (retire_i) act_d[retire_id_i] = 1'b0;
    if (accept_i) act_d[accept_id_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o  <= '0;
      act_q   <= '0;
      en_o    <= '0;
      group_o <= '0;
    end else begin
      pend_o <= pend_d;
      act_q  <= act_d;
      if (we_i && addr_i == A_SET_EN) en_o <= en_o | wdata_i;
      if (we_i && addr_i == A_CLR_EN) en_o <= en_o & ~wdata_i;
      if (we_i && addr_i == A_CTRL)   group_o <= wdata_i[10:8];
    end
  end

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_prio
    localparam logic [ADDR_W-1:0] WORD = A_PRIO + ADDR_W'(n / PER_WORD);
    localparam int                MSB  = (n % PER_WORD) * 8 + 7;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       prio_o[n] <= '0;
      else if (we_i && addr_i == WORD)   prio_o[n] <= wdata_i[MSB -: PRIO_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_SET_EN, A_CLR_EN:     rdata_o = en_o;
      A_SET_PEND, A_CLR_PEND: rdata_o = pend_o;
      A_ACTIVE:               rdata_o = act_q;
      A_CTRL:                 rdata_o[10:8] = group_o;
      default: begin
        if (addr_i[3]) begin
          for (int k = 0; k < PER_WORD; k++)
            rdata_o[k*8 +: 8] = {prio_o[{addr_i[2:0], 2'(k)}], 4'b0000};
        end
      end
    endcase
  end
endmodule

// File: rtl/irq_ctrl_pick.sv
module irq_ctrl_pick
  import irq_ctrl_pkg::*;
(
  input  logic [NUM_IRQ-1:0] req_i,
  input  prio_t              prio_i [NUM_IRQ],
  output logic               valid_o,
  output logic [ID_W-1:0]    id_o,
  output prio_t              prio_o
);
  // scan downward with <= so equal priorities settle on the lowest line
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    prio_o  = '1;
    for (int n = NUM_IRQ - 1; n >= 0; n--) begin
      if (req_i[n] && (!valid_o || prio_i[n] <= prio_o)) begin
        valid_o = 1'b1;
        id_o    = ID_W'(n);
        prio_o  = prio_i[n];
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_stack.sv
module irq_ctrl_stack #(
  parameter int DEPTH = 16,
  parameter int ID_W  = 5,
  parameter int LVL_W = 5,
  parameter logic [LVL_W-1:0] EMPTY_LVL = '1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [ID_W-1:0]  top_id_o,
  output logic [LVL_W-1:0] top_lvl_o,
  output logic [LVL_W-1:0] below_lvl_o,
  output logic [CNT_W-1:0] depth_o
);
  logic [ID_W-1:0]  id_q  [DEPTH];
  logic [LVL_W-1:0] lvl_q [DEPTH];

  wire [PTR_W-1:0] top_ptr   = PTR_W'(depth_o - CNT_W'(1));
  wire [PTR_W-1:0] below_ptr = PTR_W'(depth_o - CNT_W'(2));

  assign top_id_o    = id_q[top_ptr];
  assign top_lvl_o   = (depth_o == '0) ? EMPTY_LVL : lvl_q[top_ptr];
  assign below_lvl_o = (depth_o < CNT_W'(2)) ? EMPTY_LVL : lvl_q[below_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_o <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        id_q[i]  <= '0;
        lvl_q[i] <= '0;
      end
    end else if (push_i && pop_i && depth_o != '0) begin
      id_q[top_ptr]  <= id_i;       // tail-chain: replace in place
      lvl_q[top_ptr] <= lvl_i;
    end else if (push_i && depth_o < CNT_W'(DEPTH)) begin
      id_q[PTR_W'(depth_o)]  <= id_i;
      lvl_q[PTR_W'(depth_o)] <= lvl_i;
      depth_o <= depth_o + CNT_W'(1);
    end else if (pop_i && depth_o != '0) begin
      depth_o <= depth_o - CNT_W'(1);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] irq_i,
  input  logic        bus_we_i,
  input  logic [3:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        take_o,
  output logic [4:0]  take_id_o,
  input  logic        done_i,
  output logic [4:0]  run_level_o
);
  localparam int CNT_W = $clog2(NUM_LVL + 1);

  logic [NUM_IRQ-1:0] pend, en;
  prio_t              prio [NUM_IRQ];
  logic [2:0]         group;
  logic               cand_vld;
  logic [ID_W-1:0]    cand_id, top_id;
  prio_t              cand_prio;
  logic [LVL_W-1:0]   take_lvl, top_lvl, below_lvl, ret_lvl;
  logic [CNT_W-1:0]   stk_depth;
  logic               done_ok;

  irq_ctrl_regs u_regs (
    .clk_i, .rst_ni, .irq_i,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .accept_i(take_o), .accept_id_i(take_id_o),
    .retire_i(done_ok), .retire_id_i(top_id),
    .pend_o(pend), .en_o(en), .prio_o(prio), .group_o(group)
  );

  irq_ctrl_pick u_pick (
    .req_i(pend & en), .prio_i(prio),
    .valid_o(cand_vld), .id_o(cand_id), .prio_o(cand_prio)
  );

  assign take_lvl = LVL_W'(cand_prio >> grp_shift(group));
  assign done_ok  = done_i && stk_depth != '0;
  assign ret_lvl  = done_ok ? below_lvl : top_lvl;
  assign take_o   = cand_vld && take_lvl < ret_lvl;
  assign take_id_o = cand_id;
  assign run_level_o = top_lvl;

  irq_ctrl_stack #(
    .DEPTH(NUM_LVL), .ID_W(ID_W), .LVL_W(LVL_W), .EMPTY_LVL(IDLE_LVL)
  ) u_stack (
    .clk_i, .rst_ni,
    .push_i(take_o), .pop_i(done_ok),
    .id_i(cand_id), .lvl_i(take_lvl),
    .top_id_o(top_id), .top_lvl_o(top_lvl), .below_lvl_o(below_lvl),
    .depth_o(stk_depth)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        take_o,
  input logic [4:0]  take_id_o,
  input logic        done_i,
  input logic [4:0]  take_lvl,
  input logic [4:0]  run_level_o,
  input logic [4:0]  stk_depth,
  input logic [31:0] req
);
  // R1
  idle_in_reset_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (run_level_o == 5'd16 && !take_o));

  // R5
  strict_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !done_i) |-> take_lvl < run_level_o);

  // R10
  level_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !done_i) |=> run_level_o == $past(take_lvl));

  // R6
  take_is_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> req[take_id_o]);

  // R10
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_depth <= 5'd16);

  // R7
  last_done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !take_o && stk_depth == 5'd1) |=> run_level_o == 5'd16);
endmodule

bind prio_irq_ctrl irq_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .take_o(take_o), .take_id_o(take_id_o),
  .done_i(done_i), .take_lvl(take_lvl), .run_level_o(run_level_o),
  .stk_depth(stk_depth), .req(pend & en)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        take;
  logic [4:0]  take_id;
  logic        done = 1'b0;
  logic [4:0]  run_lvl;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .take_o(take), .take_id_o(take_id), .done_i(done), .run_level_o(run_lvl)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; #1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk); irq = m;
    @(negedge clk); irq = '0; #1;
  endtask

  task automatic step;
    @(negedge clk); #1;
  endtask

  // one-cycle handler return; reports the take seen during it
  task automatic finish(output logic tk, output logic [4:0] id);
    @(negedge clk); done = 1'b1; #1; tk = take; id = take_id;
    @(negedge clk); done = 1'b0; #1;
  endtask

  task automatic cleanup;
    wr(4'd1, '1); wr(4'd3, '1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rst_n = 1'b0; irq = '1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "take in reset", 32'(take), 0);
    check("R1", "level in reset", 32'(run_lvl), 16);
    rst_n = 1'b1; irq = '0; #1;
    rd(4'd2, d); check("R9", "pending after reset", d, 0);
    rd(4'd0, d); check("R1", "enable after reset", d, 0);
    rd(4'd4, d); check("R1", "active after reset", d, 0);
    rd(4'd5, d); check("R1", "ctrl after reset", d, 0);
    rd(4'd12, d); check("R1", "prio after reset", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(4'd0, 32'hF0); wr(4'd0, 32'h0);
    rd(4'd0, d); check("R2", "set-enable zero no effect", d, 32'hF0);
    wr(4'd1, 32'h30); wr(4'd1, 32'h0);
    rd(4'd1, d); check("R2", "clear-enable", d, 32'hC0);
    wr(4'd2, 32'h300); wr(4'd2, 32'h0);
    rd(4'd2, d); check("R2", "set-pending", d, 32'h300);
    wr(4'd3, 32'h100);
    rd(4'd3, d); check("R2", "clear-pending", d, 32'h200);
    pulse(32'h0400);
    rd(4'd2, d); check("R9", "line sets pending", d, 32'h600);
    wr(4'd15, '1);
    rd(4'd15, d); check("R3", "low nibble reads zero", d, 32'hF0F0F0F0);
    wr(4'd15, 32'h0000_0080);
    rd(4'd15, d); check("R3", "field position", d, 32'h80);
    wr(4'd5, 32'h0000_0600);
    rd(4'd5, d); check("R4", "group readback", d, 32'h600);
    cleanup();
  endtask

  task automatic t_select;
    logic [31:0] d; logic tk; logic [4:0] id;
    wr(4'd5, 32'h300);
    wr(4'd9, 32'h0000_4000);   // line 5 = 0x4
    wr(4'd10, 32'h0000_4000);  // line 9 = 0x4
    wr(4'd8, 32'h0080_0000);   // line 2 = 0x8
    wr(4'd2, 32'h224);
    wr(4'd0, 32'h224);
    check("R6", "tie to lowest line: take", 32'(take), 1);
    check("R6", "tie to lowest line: id", 32'(take_id), 5);
    step();
    check("R5", "equal level waits", 32'(take), 0);
    check("R10", "running level", 32'(run_lvl), 4);
    rd(4'd2, d); check("R8", "pending cleared on take", d, 32'h204);
    rd(4'd4, d); check("R8", "active set on take", d, 32'h20);
    finish(tk, id);
    check("R7", "tail-chain id", {tk, 27'd0, id}, {1'b1, 27'd0, 5'd9});
    rd(4'd4, d); check("R8", "active swapped", d, 32'h200);
    finish(tk, id);
    check("R6", "next best id", {tk, 27'd0, id}, {1'b1, 27'd0, 5'd2});
    check("R10", "level of line 2", 32'(run_lvl), 8);
    finish(tk, id);
    check("R7", "no take after last", 32'(tk), 0);
    check("R7", "idle after last", 32'(run_lvl), 16);
    rd(4'd4, d); check("R8", "active cleared", d, 0);
    cleanup();
  endtask

  task automatic t_subprio;
    logic [31:0] d; logic tk; logic [4:0] id;
    wr(4'd8, 32'h5000_0000);   // line 3 = 0x5
    wr(4'd9, 32'h7000_0040);   // line 4 = 0x4, line 7 = 0x7
    wr(4'd5, 32'h500);         // 2/2 split
    wr(4'd2, 32'h88);
    wr(4'd0, 32'h98);
    check("R6", "sub-priority order", {take, 26'd0, take_id}, {1'b1, 26'd0, 5'd3});
    step();
    check("R4", "2/2 level", 32'(run_lvl), 1);
    pulse(32'h10);
    check("R5", "better sub-priority does not pre-empt", 32'(take), 0);
    finish(tk, id);
    check("R7", "chain to better sub-priority", {tk, 27'd0, id}, {1'b1, 27'd0, 5'd4});
    finish(tk, id);
    check("R7", "chain to last", {tk, 27'd0, id}, {1'b1, 27'd0, 5'd7});
    finish(tk, id);
    check("R10", "idle", 32'(run_lvl), 16);
    cleanup();
  endtask

  task automatic t_nest;
    logic [31:0] d; logic tk; logic [4:0] id;
    wr(4'd10, 32'h60C0_0000);  // line 10 = 0xC, line 11 = 0x6
    wr(4'd11, 32'h0000_9020);  // line 12 = 0x2, line 13 = 0x9
    wr(4'd5, 32'h300);
    wr(4'd0, 32'h3C00);
    pulse(32'h400); step();
    check("R10", "first level", 32'(run_lvl), 12);
    pulse(32'h800);
    check("R5", "pre-empt take", {take, 26'd0, take_id}, {1'b1, 26'd0, 5'd11});
    step();
    pulse(32'h1000); step();
    check("R10", "third level", 32'(run_lvl), 2);
    rd(4'd4, d); check("R8", "three active", d, 32'h1C00);
    pulse(32'h2000);
    check("R5", "less urgent waits", 32'(take), 0);
    finish(tk, id);
    check("R7", "resume, no chain", 32'(tk), 0);
    check("R7", "resumed level", 32'(run_lvl), 6);
    finish(tk, id);
    check("R7", "chain beats return level", {tk, 27'd0, id}, {1'b1, 27'd0, 5'd13});
    check("R10", "chained level", 32'(run_lvl), 9);
    rd(4'd4, d); check("R8", "active after chain", d, 32'h2400);
    finish(tk, id); finish(tk, id);
    check("R10", "idle after unwind", 32'(run_lvl), 16);
    cleanup();
  endtask

  task automatic t_depth;
    logic tk; logic [4:0] id; int bad;
    wr(4'd5, 32'h300);
    wr(4'd12, 32'hC0D0E0F0); wr(4'd13, 32'h8090A0B0);
    wr(4'd14, 32'h40506070); wr(4'd15, 32'h00102030);
    wr(4'd0, 32'hFFFF0000);
    bad = 0;
    for (int k = 0; k < 16; k++) begin
      pulse(32'h1 << (16 + k)); step();
      if (run_lvl != 5'(15 - k)) bad++;
    end
    check("R10", "sixteen nested levels", 32'(bad), 0);
    check("R10", "deepest level", 32'(run_lvl), 0);
    bad = 0;
    for (int j = 1; j <= 16; j++) begin
      finish(tk, id);
      if (tk || run_lvl != 5'(j)) bad++;
    end
    check("R10", "unwind sixteen levels", 32'(bad), 0);
    cleanup();
  endtask

  task automatic t_group;
    logic tk; logic [4:0] id;
    wr(4'd8, 32'h0000_4050);   // line 0 = 0x5, line 1 = 0x4
    wr(4'd5, 32'h100);         // acts as 4/0
    wr(4'd0, 32'h3);
    pulse(32'h1); step();
    check("R4", "low group value level", 32'(run_lvl), 5);
    pulse(32'h2);
    check("R4", "low group value pre-empts", 32'(take), 1);
    step();
    finish(tk, id); finish(tk, id);
    wr(4'd5, 32'h700);         // 0/4: no pre-emption
    pulse(32'h1); step();
    check("R4", "0/4 level", 32'(run_lvl), 0);
    pulse(32'h2);
    check("R4", "0/4 never pre-empts", 32'(take), 0);
    finish(tk, id);
    check("R7", "0/4 chain", {tk, 27'd0, id}, {1'b1, 27'd0, 5'd1});
    finish(tk, id);
    cleanup();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_select();
    t_subprio();
    t_nest();
    t_depth();
    t_group();
    wr(4'd0, '1);
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule